// File: doc/BRIEF.md
# Conversion-Read Bus Slave with Clock Stretching

This block is the two-wire serial slave front end for a read-only data converter. It watches the bus clock and data lines through synchronisers and a stability filter, detects START, repeated START and STOP, and shifts in the address byte. When the address matches a fixed three-bit prefix followed by pin-strapped low bits, the block acknowledges, fires a start strobe toward the converter, and holds the bus clock low until the converter reports completion. It then sends the result as whole bytes, most significant byte first and each byte MSB first.

While the master acknowledges the last byte, a fresh conversion is started and the clock is stretched again, so a master can stream samples without re-addressing. A master not-acknowledge releases the bus. A byte of the form 00001xxx is taken as the high-speed entry code: the block answers it with a not-acknowledge and raises a high-speed flag that a repeated START keeps and a STOP clears. The read/write bit of a matched address is made available as a flag, so that the converter can decide whether to keep its reference powered.

Top module: `conv_read_slave`

## Requirements
- R1: After reset both line pull-downs are released, the start strobe is low, and the high-speed flag and the read/write flag are 0.
- R2: An address byte whose upper seven bits equal 011 followed by the four strap pins (bit 0 is the read/write bit) is acknowledged: SDA is low while SCL is high on the ninth clock.
- R3: An address byte with a wrong prefix or wrong pin bits is not acknowledged, and the block drives neither line until the next START. A repeated START with a matching address is then acknowledged.
- R4: After the acknowledge the block gives exactly one start strobe and holds SCL low until the converter signals completion.
- R5: The result goes out as the high byte and then the low byte, each MSB first on eight clocks; SDA is released on the ninth clock of each byte for the master's answer.
- R6: A master acknowledge after the last byte starts another conversion, with a new strobe and new stretching, and the next result follows. A master not-acknowledge ends the read: no further strobe, and both lines stay released.
- R7: A byte whose upper five bits are 00001 is answered with a not-acknowledge, after which the high-speed flag reads 1.
- R8: A STOP clears the high-speed flag; a repeated START leaves it set.
- R9: The SDA pull-down changes only while SCL is low.
- R10: The read/write bit of a matched address appears on the read/write flag output.
- R11: A completion pulse from the converter while no conversion is pending has no effect on either line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| pin_addr_i | input | PIN_W | Strapped low address bits |
| conv_done_i | input | 1 | Converter completion pulse |
| conv_data_i | input | DATA_W | Converter result, valid with conv_done_i |
| scl_pull_o | output | 1 | 1 pulls the bus clock low (stretch) |
| sda_pull_o | output | 1 | 1 pulls the bus data line low |
| conv_start_o | output | 1 | One-cycle conversion start strobe |
| hs_mode_o | output | 1 | High-speed mode flag |
| keep_ref_o | output | 1 | Read/write bit of the last matched address |

## Verification
The bench builds the block with two synchroniser stages, a stability count of three clocks, a 16-bit result and the strap pins at 1010. The short filter keeps the delay from line change to action near six clocks, so a bus half period of sixteen clocks exercises every bit, while a converter latency of forty clocks makes the stretched clock phase long enough to be measured on the bus. With a 16-bit result, both the byte-to-byte handover and the restart after the final byte are reached in a single read.

// File: rtl/conv_i2c_pkg.sv
package conv_i2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_MCODE,
      ST_CONV,
      ST_LAUNCH,
      ST_TX,
      ST_MACK
   } slv_state_t;

   // upper five bits of the high-speed entry byte
   localparam logic [4:0] HS_CODE_TOP = 5'b00001;

   localparam int BYTE_BITS = 8;

endpackage

// File: rtl/bus_line_filter.sv
module bus_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o
);
   localparam int CNT_W = $clog2(FILT_CYC + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bus_line_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_CYC < 0) begin : g_bad_filt
      $error("bus_line_filter: FILT_CYC must not be negative");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[SYNC_STAGES-2:0], line_i};
   end

   assign synced = chain[SYNC_STAGES-1];

   if (FILT_CYC <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level_o <= 1'b1;
         else        level_o <= synced;
      end
   end else begin : g_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt     <= '0;
            level_o <= 1'b1;
         end else if (synced == level_o) begin
            cnt <= '0;
         end else if (cnt == CNT_W'(FILT_CYC - 1)) begin
            cnt     <= '0;
            level_o <= synced;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // filtered level only ever moves to the synchronised value (supports R9)
   p_filter_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o != $past(level_o)) |-> (level_o == $past(synced)));

endmodule

// File: rtl/bus_edge_detect.sv
module bus_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise  = scl_f & ~scl_q;
   assign scl_fall  = ~scl_f & scl_q;
   assign start_det = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/conv_tx_shift.sv
module conv_tx_shift #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic [WIDTH-1:0] din,
   output logic             cur_bit,
   output logic             next_bit
);
   if (WIDTH < 8) begin : g_bad_width
      $error("conv_tx_shift: WIDTH must be at least 8");
   end

   logic [WIDTH-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (load)  sh <= din;
      else if (shift) sh <= {sh[WIDTH-2:0], 1'b0};
   end

   assign cur_bit  = sh[WIDTH-1];
   assign next_bit = sh[WIDTH-2];

endmodule

// File: rtl/conv_read_slave.sv
module conv_read_slave
   import conv_i2c_pkg::*;
#(
   parameter int                  PREFIX_W    = 3,
   parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 3'b011,
   parameter int                  PIN_W       = 4,
   parameter int                  DATA_W      = 16,
   parameter int                  SYNC_STAGES = 2,
   parameter int                  FILT_CYC    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [PIN_W-1:0]  pin_addr_i,
   input  logic              conv_done_i,
   input  logic [DATA_W-1:0] conv_data_i,
   output logic              scl_pull_o,
   output logic              sda_pull_o,
   output logic              conv_start_o,
   output logic              hs_mode_o,
   output logic              keep_ref_o
);
   localparam int BYTES = DATA_W / BYTE_BITS;
   localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

   if (PREFIX_W + PIN_W != 7) begin : g_bad_addr
      $error("conv_read_slave: prefix and pin bits must make seven");
   end
   if ((DATA_W % BYTE_BITS) != 0 || DATA_W < BYTE_BITS) begin : g_bad_data
      $error("conv_read_slave: DATA_W must be a whole number of bytes");
   end

   logic scl_f, sda_f;
   logic scl_rise, scl_fall, start_det, stop_det;

   bus_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) i_scl_filt (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i), .level_o(scl_f));

   bus_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) i_sda_filt (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i), .level_o(sda_f));

   bus_edge_detect i_edges (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   slv_state_t       state;
   logic [7:0]       rx_sh;
   logic [3:0]       bit_cnt;
   logic             got_byte;
   logic [IDX_W-1:0] byte_idx;
   logic             m_ack;
   logic             sda_pull_q, scl_pull_q, start_q, hs_q, rw_q;
   logic             addr_hit, code_hit;
   logic             tx_load, tx_shift_en, tx_cur, tx_next;

   assign addr_hit = (rx_sh[7:1] == {ADDR_PREFIX, pin_addr_i});
   assign code_hit = (rx_sh[7:3] == HS_CODE_TOP);

   assign tx_load     = (state == ST_CONV) && conv_done_i && !start_det && !stop_det;
   assign tx_shift_en = (state == ST_TX) && scl_fall;

   conv_tx_shift #(.WIDTH(DATA_W)) i_tx (
      .clk(clk), .rst_n(rst_n), .load(tx_load), .shift(tx_shift_en),
      .din(conv_data_i), .cur_bit(tx_cur), .next_bit(tx_next));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         rx_sh      <= '0;
         bit_cnt    <= '0;
         got_byte   <= 1'b0;
         byte_idx   <= '0;
         m_ack      <= 1'b0;
         sda_pull_q <= 1'b0;
         scl_pull_q <= 1'b0;
         start_q    <= 1'b0;
         hs_q       <= 1'b0;
         rw_q       <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (stop_det) begin
            state      <= ST_IDLE;
            hs_q       <= 1'b0;
            sda_pull_q <= 1'b0;
            scl_pull_q <= 1'b0;
         end else if (start_det) begin
            state      <= ST_ADDR;
            bit_cnt    <= '0;
            got_byte   <= 1'b0;
            sda_pull_q <= 1'b0;
            scl_pull_q <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (scl_rise && !got_byte) begin
                     rx_sh <= {rx_sh[6:0], sda_f};
                     if (bit_cnt == 4'd7) got_byte <= 1'b1;
                     else                 bit_cnt  <= bit_cnt + 4'd1;
                  end else if (scl_fall && got_byte) begin
                     if (addr_hit) begin
                        sda_pull_q <= 1'b1;
                        rw_q       <= rx_sh[0];
                        state      <= ST_AACK;
                     end else if (code_hit) begin
                        state <= ST_MCODE;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     sda_pull_q <= 1'b0;
                     scl_pull_q <= 1'b1;
                     start_q    <= 1'b1;
                     byte_idx   <= '0;
                     state      <= ST_CONV;
                  end
               end
               ST_MCODE: begin
                  if (scl_fall) begin
                     hs_q  <= 1'b1;
                     state <= ST_IDLE;
                  end
               end
               ST_CONV: begin
                  if (conv_done_i) begin
                     sda_pull_q <= ~conv_data_i[DATA_W-1];
                     state      <= ST_LAUNCH;
                  end
               end
               ST_LAUNCH: begin
                  scl_pull_q <= 1'b0;
                  bit_cnt    <= '0;
                  state      <= ST_TX;
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bit_cnt == 4'd8) begin
                        sda_pull_q <= 1'b0;
                        m_ack      <= 1'b0;
                        state      <= ST_MACK;
                     end else begin
                        sda_pull_q <= ~tx_next;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     m_ack <= ~sda_f;
                  end else if (scl_fall) begin
                     if (!m_ack) begin
                        state <= ST_IDLE;
                     end else if (byte_idx == IDX_W'(BYTES - 1)) begin
                        scl_pull_q <= 1'b1;
                        start_q    <= 1'b1;
                        byte_idx   <= '0;
                        state      <= ST_CONV;
                     end else begin
                        byte_idx   <= byte_idx + 1'b1;
                        sda_pull_q <= ~tx_cur;
                        bit_cnt    <= '0;
                        state      <= ST_TX;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_pull_o   = sda_pull_q;
   assign scl_pull_o   = scl_pull_q;
   assign conv_start_o = start_q;
   assign hs_mode_o    = hs_q;
   assign keep_ref_o   = rw_q;

   p_sda_moves_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull_q != $past(sda_pull_q)) |-> !scl_f);

   p_start_stretches_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> (scl_pull_q && !sda_pull_q));

   p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);

   p_stretch_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_CONV) && !conv_done_i && !stop_det) |=> scl_pull_q);

   p_stop_leaves_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !hs_q);

   p_code_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MCODE) |-> !sda_pull_q);

   p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (!sda_pull_q && !scl_pull_q));

endmodule

// File: tb/test_conv_read_slave.sv
`timescale 1ns/100ps
module test_conv_read_slave;
   localparam int HP  = 16;
   localparam int LAT = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        scl_bus, sda_bus;
   logic [3:0]  pins = 4'b1010;
   logic        conv_done = 1'b0;
   logic [15:0] conv_data = '0;
   logic        scl_pull, sda_pull, conv_start, hs_mode, keep_ref;

   int errors = 0;
   int checks = 0;
   int n_starts = 0;
   int last_wait = 0;
   int r9_viol = 0;
   logic finished = 1'b0;

   logic [15:0] vals [4];
   initial begin
      vals[0] = 16'hA5C3;
      vals[1] = 16'h0001;
      vals[2] = 16'hFFFE;
      vals[3] = 16'h8000;
   end

   always #10 clk = ~clk;

   assign scl_bus = m_scl & ~scl_pull;
   assign sda_bus = m_sda & ~sda_pull;

   conv_read_slave #(.DATA_W(16), .SYNC_STAGES(2), .FILT_CYC(3)) i_conv_read_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .pin_addr_i(pins), .conv_done_i(conv_done), .conv_data_i(conv_data),
      .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .conv_start_o(conv_start),
      .hs_mode_o(hs_mode), .keep_ref_o(keep_ref));

   // converter model
   initial begin
      forever begin
         @(negedge clk);
         if (conv_start) begin
            n_starts++;
            repeat (LAT) @(negedge clk);
            conv_data = vals[(n_starts - 1) % 4];
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
         end
      end
   end

   // R9 monitor: slave SDA pull must not move while the bus clock is high
   initial begin
      logic prev = 1'b0;
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && (sda_pull != prev) && scl_bus) r9_viol++;
         prev = sda_pull;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clock_bit(input logic b, output logic r);
      m_sda = b;
      wait_clk(HP);
      m_scl = 1'b1;
      last_wait = 0;
      @(negedge clk);
      while (!scl_bus) begin
         last_wait++;
         @(negedge clk);
      end
      wait_clk(HP / 2);
      r = sda_bus;
      wait_clk(HP / 2);
      m_scl = 1'b0;
      wait_clk(4);
   endtask

   task automatic bus_start;
      m_sda = 1'b1;
      m_scl = 1'b1;
      wait_clk(HP);
      m_sda = 1'b0;
      wait_clk(HP);
      m_scl = 1'b0;
      wait_clk(4);
   endtask

   task automatic bus_rstart;
      m_sda = 1'b1;
      wait_clk(HP);
      m_scl = 1'b1;
      wait_clk(HP);
      m_sda = 1'b0;
      wait_clk(HP);
      m_scl = 1'b0;
      wait_clk(4);
   endtask

   task automatic bus_stop;
      m_sda = 1'b0;
      wait_clk(HP);
      m_scl = 1'b1;
      wait_clk(HP);
      m_sda = 1'b1;
      wait_clk(HP);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic acked);
      logic r;
      for (int i = 7; i >= 0; i--) clock_bit(d[i], r);
      clock_bit(1'b1, r);
      acked = ~r;
   endtask

   // read one result word; master answers each byte with ack, except nack_last on the last
   task automatic read_word(input logic nack_last, output logic [15:0] w, output int first_wait);
      logic r;
      w = '0;
      first_wait = 0;
      for (int by = 0; by < 2; by++) begin
         for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, r);
            if (by == 0 && i == 0) first_wait = last_wait;
            w = {w[14:0], r};
         end
         clock_bit((by == 1) ? nack_last : 1'b0, r);
      end
   endtask

   task automatic t_reset;
      chk("R1 sda pull", {31'd0, sda_pull}, 32'd0);
      chk("R1 scl pull", {31'd0, scl_pull}, 32'd0);
      chk("R1 start strobe", {31'd0, conv_start}, 32'd0);
      chk("R1 hs flag", {31'd0, hs_mode}, 32'd0);
      chk("R1 rw flag", {31'd0, keep_ref}, 32'd0);
   endtask

   task automatic t_single_read;
      logic ack;
      logic [15:0] w;
      int fw, s0;
      s0 = n_starts;
      bus_start();
      send_byte(8'h75, ack);
      chk("R2 address ack", {31'd0, ack}, 32'd1);
      read_word(1'b1, w, fw);
      chk("R4 one strobe", n_starts - s0, 32'd1);
      chk("R4 clock stretched", {31'd0, (fw > 0)}, 32'd1);
      chk("R5 result word", {16'd0, w}, {16'd0, vals[s0 % 4]});
      chk("R10 rw flag set", {31'd0, keep_ref}, 32'd1);
      wait_clk(3 * HP);
      chk("R6 nack no restart", n_starts - s0, 32'd1);
      chk("R6 nack lines free", {30'd0, sda_pull, scl_pull}, 32'd0);
      chk("R8 hs stays off", {31'd0, hs_mode}, 32'd0);
      bus_stop();
   endtask

   task automatic t_stream;
      logic ack;
      logic [15:0] w1, w2;
      int fw, s0;
      s0 = n_starts;
      bus_start();
      send_byte(8'h74, ack);
      chk("R2 address ack rw0", {31'd0, ack}, 32'd1);
      chk("R10 rw flag clear", {31'd0, keep_ref}, 32'd0);
      read_word(1'b0, w1, fw);
      chk("R5 first streamed word", {16'd0, w1}, {16'd0, vals[s0 % 4]});
      read_word(1'b1, w2, fw);
      chk("R6 ack restarts", n_starts - s0, 32'd2);
      chk("R6 restart stretched", {31'd0, (fw > 0)}, 32'd1);
      chk("R6 second word", {16'd0, w2}, {16'd0, vals[(s0 + 1) % 4]});
      bus_stop();
   endtask

   task automatic t_mismatch;
      logic ack, r;
      logic [8:0] seen;
      int s0;
      s0 = n_starts;
      bus_start();
      send_byte(8'h77, ack);
      chk("R3 pin mismatch nack", {31'd0, ack}, 32'd0);
      seen = '0;
      for (int i = 0; i < 9; i++) begin
         clock_bit(1'b1, r);
         seen = {seen[7:0], r};
      end
      chk("R3 sda undriven", {23'd0, seen}, 32'h1FF);
      chk("R3 no strobe", n_starts - s0, 32'd0);
      bus_rstart();
      send_byte(8'hF5, ack);
      chk("R3 prefix mismatch nack", {31'd0, ack}, 32'd0);
      bus_rstart();
      send_byte(8'h75, ack);
      chk("R3 match after restart", {31'd0, ack}, 32'd1);
      begin
         logic [15:0] w;
         int fw;
         read_word(1'b1, w, fw);
         chk("R5 word after restart", {16'd0, w}, {16'd0, vals[s0 % 4]});
      end
      bus_stop();
   endtask

   task automatic t_high_speed;
      logic ack;
      logic [15:0] w;
      int fw, s0;
      s0 = n_starts;
      bus_start();
      send_byte(8'h0B, ack);
      chk("R7 code nack", {31'd0, ack}, 32'd0);
      wait_clk(HP);
      chk("R7 hs flag set", {31'd0, hs_mode}, 32'd1);
      bus_rstart();
      send_byte(8'h75, ack);
      chk("R8 rstart keeps hs", {31'd0, hs_mode}, 32'd1);
      chk("R2 ack in hs", {31'd0, ack}, 32'd1);
      read_word(1'b1, w, fw);
      chk("R5 word in hs", {16'd0, w}, {16'd0, vals[s0 % 4]});
      bus_stop();
      wait_clk(HP);
      chk("R8 stop clears hs", {31'd0, hs_mode}, 32'd0);
   endtask

   task automatic t_stray_done;
      int s0;
      s0 = n_starts;
      wait_clk(4);
      conv_data = 16'h0000;
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      wait_clk(12);
      chk("R11 stray done lines", {30'd0, sda_pull, scl_pull}, 32'd0);
      chk("R11 stray done no strobe", n_starts - s0, 32'd0);
   endtask

   initial begin
      wait_clk(5);
      t_reset();
      rst_n = 1'b1;
      wait_clk(10);
      t_reset();
      t_single_read();
      t_stream();
      t_mismatch();
      t_high_speed();
      t_stray_done();
      chk("R9 sda moves only with scl low", r9_viol, 32'd0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule